// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps wall-clock time as six binary counters: second, minute, hour, day of month, month and two-digit year. A free-running prescaler counts strobes from a time-base tick input. Every `TICKS_PER_SEC` strobes it advances the second counter. The carry then ripples up the calendar. Month lengths and leap years are resolved in hardware.

The time is set through a small register port and read back through a combinational read port. The same port selects a periodic interrupt at half-second, one-second or one-minute intervals. It also holds a signed trim value that lengthens or shortens one second per minute to correct crystal error. Each interrupt appears as a one-cycle pulse on `irq`. The same event sets a sticky flag that software clears.

Top module: `rtc_calendar`

## Requirements
- R1: After a synchronous active-low reset, second, minute and hour read 0, day and month read 1, year reads 0, and the interrupt select, the trim value, the flag and `irq` are all 0.
- R2: The second advances after `TICKS_PER_SEC` tick strobes. A second at or above 59 wraps to 0 and carries into the minute. A minute at or above 59 wraps to 0 and carries into the hour. An hour at or above 23 wraps to 0 and carries into the day. With no tick and no write, no register changes.
- R3: On a day carry, the day wraps to 1 once it is at or above the month length: 30 for months 4, 6, 9 and 11, and 31 for all other months except 2. The month wraps from 12 (or above) to 1 and carries into the year, and the year wraps from 99 (or above) to 0.
- R4: February (month 2) has 29 days when the year is divisible by 4 and 28 days otherwise.
- R5: Register addresses are 0 second, 1 minute, 2 hour, 3 day, 4 month, 5 year, 6 interrupt control and 7 trim. Written values keep the low 6, 6, 5, 5, 4 and 7 bits. A write to addresses 0 to 5 resets the sub-second phase. If such a write falls in the same cycle as a tick that would end a second, that second event is lost, and the next second ends `TICKS_PER_SEC` ticks later.
- R6: Address 6 bits [1:0] select the interrupt: 0 none, 1 every half second (at phase `TICKS_PER_SEC/2-1` and at each second event), 2 every second event, 3 every minute carry.
- R7: `irq` is high for exactly one cycle, in the cycle after the edge on which the selected event occurs. The same event sets a sticky flag, read as bit 7 of address 6. Any write to address 6 clears the flag, but a coincident event wins over the clear.
- R8: Address 7 holds a `TRIM_W`-bit two's-complement trim T, read back sign-extended to 8 bits. The second that begins while the second counter reads 0 lasts `TICKS_PER_SEC - T` ticks. Every other second lasts `TICKS_PER_SEC` ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Time-base strobe, one cycle per sub-second step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
A software write that sets a time register can land in the same cycle as the tick that ends a second. The write must then win, and the increment and its interrupt must both be lost. The bench advances the phase to the last tick of a second and then issues a minute write together with that tick. It then checks that the second is unchanged and that a full second passes before the next increment. A second collision is between a flag clear and a selected event in the same cycle. Here the flag must stay set. Random stimulus mixes writes with ticks so that both collisions also occur by chance, and every cycle's `irq` and each register read are compared with the bench's own model.

// File: rtl/rtc_pkg.sv
// Shared types and the month-length function for the calendar clock.
// Assumes binary (not BCD) counters and a two-digit year.
package rtc_pkg;

    typedef enum logic [2:0] {
        ADDR_SEC  = 3'd0,
        ADDR_MIN  = 3'd1,
        ADDR_HOUR = 3'd2,
        ADDR_DAY  = 3'd3,
        ADDR_MON  = 3'd4,
        ADDR_YEAR = 3'd5,
        ADDR_IRQ  = 3'd6,
        ADDR_TRIM = 3'd7
    } rtc_addr_e;

    typedef enum logic [1:0] {
        IRQ_OFF  = 2'd0,
        IRQ_HALF = 2'd1,
        IRQ_SEC  = 2'd2,
        IRQ_MIN  = 2'd3
    } rtc_irq_sel_e;

    typedef struct packed {
        logic [6:0] yr;
        logic [3:0] mon;
        logic [4:0] day;
        logic [4:0] hr;
        logic [5:0] min;
        logic [5:0] sec;
    } rtc_time_t;

    // Last day of a month; any year whose low two bits are zero is a leap year.
    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] yr);
        case (mon)
            4'd2:                      month_len = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   month_len = 5'd30;
            default:                   month_len = 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescale.sv
// Sub-second prescaler: counts tick strobes and marks the half-second
// point and the end of each second. When trim_en is high the second is
// shortened by a signed trim. Assumes TPS even and |trim| < TPS/2.
module rtc_prescale #(
    parameter int TPS    = 16,
    parameter int TRIM_W = 3,
    parameter int PH_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     clr,
    input  logic                     trim_en,
    input  logic signed [TRIM_W-1:0] trim,
    output logic                     half_evt,
    output logic                     sec_evt,
    output logic [PH_W-1:0]          phase
);
    localparam int HALF = TPS / 2;

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] limit;
    int              lim_i;

    // Last phase value of the current second, trimmed when enabled.
    always_comb begin
        lim_i = TPS - 1 - (trim_en ? int'(trim) : 0);
        limit = PH_W'(lim_i);
    end

    assign sec_evt  = tick && !clr && (phase_q >= limit);
    assign half_evt = tick && !clr && (phase_q == PH_W'(HALF - 1));
    assign phase    = phase_q;

    // Phase counter: cleared by time writes, wraps at each second event.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (clr)     phase_q <= '0;
        else if (tick)    phase_q <= sec_evt ? '0 : phase_q + 1'b1;
    end

endmodule

// File: rtl/rtc_counters.sv
// Calendar counter chain: seconds to years with month-length and leap-year
// rollover. A register write replaces one field; the caller masks sec_evt
// in a write cycle. Values at or above a field's top wrap on the next carry.
module rtc_counters
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_evt,
    input  logic       wr_time,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output rtc_time_t  now,
    output logic       min_evt
);
    rtc_time_t t_q;
    logic s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap;

    // Carry chain, each stage gated by the one below.
    always_comb begin
        s_wrap  = sec_evt && (t_q.sec >= 6'd59);
        m_wrap  = s_wrap  && (t_q.min >= 6'd59);
        h_wrap  = m_wrap  && (t_q.hr  >= 5'd23);
        d_wrap  = h_wrap  && (t_q.day >= month_len(t_q.mon, t_q.yr));
        mo_wrap = d_wrap  && (t_q.mon >= 4'd12);
    end

    assign now     = t_q;
    assign min_evt = s_wrap;

    // Field update: write has priority, otherwise advance on carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{yr: 7'd0, mon: 4'd1, day: 5'd1, hr: 5'd0, min: 6'd0, sec: 6'd0};
        end else if (wr_time) begin
            case (wr_addr)
                ADDR_SEC:  t_q.sec <= wr_data[5:0];
                ADDR_MIN:  t_q.min <= wr_data[5:0];
                ADDR_HOUR: t_q.hr  <= wr_data[4:0];
                ADDR_DAY:  t_q.day <= wr_data[4:0];
                ADDR_MON:  t_q.mon <= wr_data[3:0];
                ADDR_YEAR: t_q.yr  <= wr_data[6:0];
                default:   ;
            endcase
        end else begin
            if (sec_evt) t_q.sec <= s_wrap  ? 6'd0 : t_q.sec + 6'd1;
            if (s_wrap)  t_q.min <= m_wrap  ? 6'd0 : t_q.min + 6'd1;
            if (m_wrap)  t_q.hr  <= h_wrap  ? 5'd0 : t_q.hr  + 5'd1;
            if (h_wrap)  t_q.day <= d_wrap  ? 5'd1 : t_q.day + 5'd1;
            if (d_wrap)  t_q.mon <= mo_wrap ? 4'd1 : t_q.mon + 4'd1;
            if (mo_wrap) t_q.yr  <= (t_q.yr >= 7'd99) ? 7'd0 : t_q.yr + 7'd1;
        end
    end

endmodule

// File: rtl/rtc_irq.sv
// Periodic interrupt: picks one event source, registers it into a
// one-cycle pulse and a sticky flag. A new event wins over a clear.
module rtc_irq
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_evt,
    input  logic       sec_evt,
    input  logic       min_evt,
    input  logic [1:0] sel,
    input  logic       clr_flag,
    output logic       irq,
    output logic       flag
);
    logic hit;

    // Source selection by the programmed period.
    always_comb begin
        case (sel)
            IRQ_HALF: hit = half_evt || sec_evt;
            IRQ_SEC:  hit = sec_evt;
            IRQ_MIN:  hit = min_evt;
            default:  hit = 1'b0;
        endcase
    end

    // Pulse and sticky flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq  <= 1'b0;
            flag <= 1'b0;
        end else begin
            irq  <= hit;
            flag <= hit ? 1'b1 : (clr_flag ? 1'b0 : flag);
        end
    end

endmodule

// File: rtl/rtc_calendar.sv
// Calendar real-time clock top: register port, read mux, interrupt
// select and trim storage around the prescaler, counter chain and
// interrupt stage. Assumes TRIM_W <= 7 and 2**(TRIM_W-1) < TICKS_PER_SEC/2.
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 16,
    parameter int TRIM_W        = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       irq
);
    localparam int PH_W = $clog2(TICKS_PER_SEC + 2**(TRIM_W-1) + 1);

    logic                     time_wr, ctl_wr, trim_wr;
    logic [1:0]               sel_q;
    logic signed [TRIM_W-1:0] trim_q;
    rtc_time_t                now;
    logic                     half_evt, sec_evt, min_evt, irq_flag;
    logic [PH_W-1:0]          phase;

    assign time_wr = wr_en && (wr_addr <= ADDR_YEAR);
    assign ctl_wr  = wr_en && (wr_addr == ADDR_IRQ);
    assign trim_wr = wr_en && (wr_addr == ADDR_TRIM);

    // Interrupt select and trim registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 2'd0;
            trim_q <= '0;
        end else begin
            if (ctl_wr)  sel_q  <= wr_data[1:0];
            if (trim_wr) trim_q <= signed'(wr_data[TRIM_W-1:0]);
        end
    end

    rtc_prescale #(.TPS(TICKS_PER_SEC), .TRIM_W(TRIM_W), .PH_W(PH_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clr      (time_wr),
        .trim_en  (now.sec == 6'd0),
        .trim     (trim_q),
        .half_evt (half_evt),
        .sec_evt  (sec_evt),
        .phase    (phase)
    );

    rtc_counters u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .sec_evt (sec_evt),
        .wr_time (time_wr),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .now     (now),
        .min_evt (min_evt)
    );

    rtc_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_evt (half_evt),
        .sec_evt  (sec_evt),
        .min_evt  (min_evt),
        .sel      (sel_q),
        .clr_flag (ctl_wr),
        .irq      (irq),
        .flag     (irq_flag)
    );

    // Read mux: zero-extended fields, control byte, sign-extended trim.
    always_comb begin
        case (rd_addr)
            ADDR_SEC:  rd_data = {2'b0, now.sec};
            ADDR_MIN:  rd_data = {2'b0, now.min};
            ADDR_HOUR: rd_data = {3'b0, now.hr};
            ADDR_DAY:  rd_data = {3'b0, now.day};
            ADDR_MON:  rd_data = {4'b0, now.mon};
            ADDR_YEAR: rd_data = {1'b0, now.yr};
            ADDR_IRQ:  rd_data = {irq_flag, 5'b0, sel_q};
            default:   rd_data = {{(8-TRIM_W){trim_q[TRIM_W-1]}}, trim_q};
        endcase
    end

endmodule

// File: rtl/rtc_calendar_chk.sv
// Property checker for rtc_calendar, attached by bind. Observes the
// prescaler, counter chain and interrupt stage over time.
module rtc_calendar_chk
    import rtc_pkg::*;
#(
    parameter int TPS    = 16,
    parameter int TRIM_W = 3,
    parameter int PH_W   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            wr_en,
    input logic            time_wr,
    input logic            sec_evt,
    input rtc_time_t       now,
    input logic [PH_W-1:0] phase,
    input logic            irq,
    input logic            flag
);
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(now)); // R2

    AST_SEC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_evt && now.sec >= 6'd59) |=> (now.sec == 6'd0)); // R2

    AST_WRITE_CLEARS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr |=> (phase == '0)); // R5

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R7

    AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R7

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= PH_W'(TPS - 1 + 2**(TRIM_W-1))); // R8

endmodule

bind rtc_calendar rtc_calendar_chk #(
    .TPS    (TICKS_PER_SEC),
    .TRIM_W (TRIM_W),
    .PH_W   (PH_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .time_wr (time_wr),
    .sec_evt (sec_evt),
    .now     (now),
    .phase   (phase),
    .irq     (irq),
    .flag    (irq_flag)
);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
    localparam int CLK_P = 10;
    localparam int TPS   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    int m_sec, m_min, m_hr, m_day, m_mon, m_yr;
    int m_phase, m_trim, m_sel, m_flag, exp_irq;

    always #(CLK_P/2) clk = ~clk;

    rtc_calendar #(.TICKS_PER_SEC(TPS), .TRIM_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int days_of(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic int exp_read(input int a);
        case (a)
            0: return m_sec;
            1: return m_min;
            2: return m_hr;
            3: return m_day;
            4: return m_mon;
            5: return m_yr;
            6: return (m_flag << 7) | m_sel;
            default: return m_trim & 8'hFF;
        endcase
    endfunction

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0;
        m_phase = 0; m_trim = 0; m_sel = 0; m_flag = 0; exp_irq = 0;
    endtask

    // One clock edge of the reference model, from pre-edge state.
    task automatic model_step(input bit tk, input bit we, input int ad, input int dt);
        bit tw, sev, hev, mev, hit;
        int lim;
        tw  = we && ad <= 5;
        lim = TPS - 1 - ((m_sec == 0) ? m_trim : 0);
        sev = tk && !tw && m_phase >= lim;
        hev = tk && !tw && m_phase == TPS/2 - 1;
        mev = sev && m_sec >= 59;
        hit = (m_sel == 1) ? (hev || sev) : (m_sel == 2) ? sev : (m_sel == 3) ? mev : 1'b0;
        exp_irq = hit;
        if (hit) m_flag = 1; else if (we && ad == 6) m_flag = 0;
        if (tw) m_phase = 0; else if (tk) m_phase = sev ? 0 : m_phase + 1;
        if (sev) begin
            if (m_sec >= 59) begin
                m_sec = 0;
                if (m_min >= 59) begin
                    m_min = 0;
                    if (m_hr >= 23) begin
                        m_hr = 0;
                        if (m_day >= days_of(m_mon, m_yr)) begin
                            m_day = 1;
                            if (m_mon >= 12) begin
                                m_mon = 1;
                                m_yr = (m_yr >= 99) ? 0 : m_yr + 1;
                            end else m_mon++;
                        end else m_day++;
                    end else m_hr++;
                end else m_min++;
            end else m_sec++;
        end
        if (we) begin
            case (ad)
                0: m_sec = dt & 63;
                1: m_min = dt & 63;
                2: m_hr  = dt & 31;
                3: m_day = dt & 31;
                4: m_mon = dt & 15;
                5: m_yr  = dt & 127;
                6: m_sel = dt & 3;
                default: m_trim = ((dt & 7) >= 4) ? (dt & 7) - 8 : (dt & 7);
            endcase
        end
    endtask

    task automatic cyc(input bit tk, input bit we, input int ad, input int dt);
        @(negedge clk);
        tick = tk; wr_en = we; wr_addr = ad[2:0]; wr_data = dt[7:0];
        @(posedge clk);
        model_step(tk, we, ad, dt);
        #1;
        chk(irq === exp_irq[0], "R7 irq pulse timing", int'(irq), exp_irq);
    endtask

    task automatic setw(input int ad, input int dt);
        cyc(1'b0, 1'b1, ad, dt);
    endtask

    task automatic ticks(input int n);
        repeat (n) cyc(1'b1, 1'b0, 0, 0);
    endtask

    task automatic set_time(input int yr, input int mon, input int day,
                            input int hr, input int mn, input int sc);
        setw(5, yr); setw(4, mon); setw(3, day); setw(2, hr); setw(1, mn); setw(0, sc);
    endtask

    task automatic read_all(input string req);
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        for (int a = 0; a < 8; a++) begin
            rd_addr = a[2:0];
            #1;
            chk(int'(rd_data) == exp_read(a), req, int'(rd_data), exp_read(a));
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; fails++;
        $display("FAIL R2 watchdog: act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        read_all("R1 reset values");

        // Full rollover: end of year 99 to year 0
        setw(6, 2);
        set_time(99, 12, 31, 23, 59, 59);
        ticks(TPS);
        read_all("R3 year and month wrap");

        // Leap February
        set_time(4, 2, 28, 23, 59, 59); ticks(TPS);
        read_all("R4 leap Feb 29");
        setw(2, 23); setw(1, 59); setw(0, 59); ticks(TPS);
        read_all("R4 leap Feb 29 to Mar 1");
        set_time(5, 2, 28, 23, 59, 59); ticks(TPS);
        read_all("R4 common Feb 28 to Mar 1");
        set_time(21, 4, 30, 23, 59, 59); ticks(TPS);
        read_all("R3 30-day month wrap");
        set_time(21, 5, 30, 23, 59, 59); ticks(TPS);
        read_all("R3 31-day month no wrap");

        // Interrupt modes
        setw(6, 1); ticks(2 * TPS);
        read_all("R6 half-second mode");
        setw(6, 3); setw(0, 57); ticks(4 * TPS);
        read_all("R6 minute mode");
        setw(6, 0); ticks(TPS);
        read_all("R7 flag cleared by control write");

        // Set wins over clear: control write on a second boundary
        setw(6, 2); setw(0, 10); ticks(TPS - 1);
        cyc(1'b1, 1'b1, 6, 2);
        read_all("R7 event wins over flag clear");

        // Trim: +3 shortens the :00 second to 13 ticks, -4 lengthens to 20
        setw(7, 3); setw(0, 0); ticks(TPS - 4);
        read_all("R8 trimmed second not yet over");
        ticks(1);
        read_all("R8 trimmed second ends after 13 ticks");
        setw(7, 8'hFC); setw(0, 0); ticks(TPS + 3);
        read_all("R8 negative trim still counting");
        ticks(1);
        read_all("R8 negative trim ends after 20 ticks");
        setw(7, 0);

        // Write collides with the tick that ends a second
        setw(0, 10); ticks(TPS - 1);
        cyc(1'b1, 1'b1, 1, 7);
        read_all("R5 collided second event dropped");
        ticks(TPS - 1);
        read_all("R5 phase restarted by write");
        ticks(1);
        read_all("R2 second advances after full count");

        // Constrained random mix
        for (int i = 0; i < 6000; i++) begin
            bit tk, we;
            int ad, dt;
            tk = ($urandom % 4) != 0;
            we = ($urandom % 50) == 0;
            ad = $urandom % 8;
            dt = $urandom % 256;
            if (we && ad <= 5 && ($urandom % 2) == 0) dt = 55 + ($urandom % 5);
            cyc(tk, we, ad, dt);
            if (i % 250 == 249) read_all("R2 R3 random state");
        end

        summary();
        $finish;
    end

endmodule